// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block gives a small 32-bit processor a serial console. It sits on a plain memory-mapped bus and decodes its three registers inside a 4 KB window whose base is a parameter. By default the base is 0x1000_0000. A store to the transmit register sends one byte on the line. A load from the receive register returns the oldest received byte and removes it from a small receive queue. A load from the status register shows whether the transmitter is busy and whether received data is waiting.

The line format is fixed: one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. The bit period is the system clock divided by the baud rate, rounded to the nearest whole clock. With a 50 MHz clock and 115200 baud, one bit lasts 434 clocks. The receive input passes through a two-stage synchroniser. The receiver confirms the start bit at its midpoint and then samples each later bit at its centre.

Each bus access takes one cycle. Read data appears on `bus_rdata` in the cycle after the read strobe, and `bus_rdata` is zero in every other cycle. There is no transmit queue, so software polls the busy flag before each store.

Top module: `mmio_uart`

## Requirements
- R1: Only addresses inside the 4 KB window at BASE_ADDR are decoded. The byte offsets are 0x000 (transmit), 0x004 (receive) and 0x008 (status). A read of any other offset, of offset 0x000, or of any address outside the window returns zero. An access outside the window has no effect.
- R2: When the transmitter is idle, a write to offset 0x000 starts a frame that carries bits [7:0] of the write data. From the clock edge of the write, the line goes low for one bit period (start bit), then carries the eight data bits least significant first, then is high for one bit period (stop bit). One bit period is round(CLK_HZ/BAUD) clocks.
- R3: A status read returns bit 0 = transmitter busy and bit 1 = receive data available. Bits [31:2] are zero. Bit 0 is set from the clock edge after the accepted write until the stop bit has been on the line for a full bit period.
- R4: A write to offset 0x000 while the transmitter is busy is ignored. The frame in progress is not changed, and no second frame follows it.
- R5: A read of offset 0x004 returns the oldest queued byte in bits [7:0], with zeros above, and removes that byte. A read of offset 0x004 while the queue is empty returns zero and leaves the queue unchanged.
- R6: Status bit 1 is high exactly while the receive queue holds at least one byte. A status read does not change any state.
- R7: A low pulse on the receive line that is no longer low at the middle of the start bit is rejected, and no byte is queued.
- R8: A received frame whose stop bit samples low is discarded. The receiver then accepts the next valid frame.
- R9: A byte that completes while the queue holds FIFO_DEPTH bytes is dropped, and the bytes already in the queue are kept in order.
- R10: Writes to offsets 0x004 and 0x008 have no effect: they change neither the queue nor the transmitter.
- R11: After reset the transmit line is high, the status reads zero and the queue is empty. While the transmitter is idle the line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the bus access |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data; only bits [7:0] are used |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re, otherwise zero |
| uart_rx | input | 1 | Serial receive line, asynchronous |
| uart_tx | output | 1 | Serial transmit line, idle high |

## Verification
The bench sends every byte value through both the transmitter and the receiver, at a reduced bit period of 16 clocks. A bit-order or bit-count error therefore shows up on some value. The bench fires a second store into the middle of a frame. A design that does not ignore it would corrupt the remaining bits or send an extra frame. The bench also checks the busy flag just before and just after the end of the stop bit. A flag that drops one bit early would let software overwrite a frame that is still being sent. On the receive side the bench targets:
- a short start glitch, which a design without the midpoint check would accept as a byte;
- a frame with a low stop bit, which a lax receiver would queue;
- one frame more than the queue can hold, where a wrapping pointer would overwrite the oldest byte;
- empty reads and status reads, where a design with a stray pop would lose data.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

    // Phase of a serial frame, shared by transmitter and receiver
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_phase_e;

    // Register offsets inside the 4 KB window
    localparam int          WIN_BITS = 12;
    localparam logic [11:0] OFS_TXD  = 12'h000;
    localparam logic [11:0] OFS_RXD  = 12'h004;
    localparam logic [11:0] OFS_STAT = 12'h008;

    // Status bit positions
    localparam int STAT_TX_BUSY  = 0;
    localparam int STAT_RX_AVAIL = 1;

endpackage

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import mmio_uart_pkg::*;
#(
    parameter int CPB       = 434,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] data_i,
    output logic                 busy_o,
    output logic                 line_o
);

    localparam int CW = $clog2(CPB + 1);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(CPB - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    typedef struct packed {
        line_phase_e          phase;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bitn;
        logic [DATA_BITS-1:0] shift;
        logic                 line;
    } tx_state_t;

    localparam tx_state_t TX_RESET = '{phase: LN_IDLE, cnt: '0, bitn: '0, shift: '0, line: 1'b1};

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (q.phase == LN_IDLE) begin
            d.line = 1'b1;
            if (start_i) begin
                d.phase = LN_START;
                d.line  = 1'b0;
                d.cnt   = '0;
                d.shift = data_i;
            end
        end else if (q.cnt == CNT_LAST) begin
            d.cnt = '0;
            case (q.phase)
                LN_START: begin
                    d.phase = LN_DATA;
                    d.bitn  = '0;
                    d.line  = q.shift[0];
                end
                LN_DATA: begin
                    if (q.bitn == BIT_LAST) begin
                        d.phase = LN_STOP;
                        d.line  = 1'b1;
                    end else begin
                        d.shift = {1'b0, q.shift[DATA_BITS-1:1]};
                        d.line  = q.shift[1];
                        d.bitn  = q.bitn + 1'b1;
                    end
                end
                default: begin
                    d.phase = LN_IDLE;
                    d.line  = 1'b1;
                end
            endcase
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= TX_RESET;
        else        q <= d;
    end

    assign busy_o = (q.phase != LN_IDLE);
    assign line_o = q.line;

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import mmio_uart_pkg::*;
#(
    parameter int CPB       = 434,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    output logic                 valid_o,
    output logic [DATA_BITS-1:0] data_o
);

    localparam int CW = $clog2(CPB + 1);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(CPB - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(CPB / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    typedef struct packed {
        logic [1:0]           sync;
        line_phase_e          phase;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bitn;
        logic [DATA_BITS-1:0] shift;
        logic                 valid;
    } rx_state_t;

    localparam rx_state_t RX_RESET = '{sync: 2'b11, phase: LN_IDLE, cnt: '0, bitn: '0, shift: '0, valid: 1'b0};

    rx_state_t q, d;
    logic      rxs;

    assign rxs = q.sync[1];

    always_comb begin
        d       = q;
        d.sync  = {q.sync[0], line_i};
        d.valid = 1'b0;
        case (q.phase)
            LN_IDLE: begin
                if (!rxs) begin
                    d.phase = LN_START;
                    d.cnt   = '0;
                end
            end
            LN_START: begin
                if (q.cnt == CNT_HALF) begin
                    d.cnt   = '0;
                    d.bitn  = '0;
                    d.phase = rxs ? LN_IDLE : LN_DATA;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            LN_DATA: begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt   = '0;
                    d.shift = {rxs, q.shift[DATA_BITS-1:1]};
                    if (q.bitn == BIT_LAST) d.phase = LN_STOP;
                    else                    d.bitn  = q.bitn + 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.cnt == CNT_LAST) begin
                    d.cnt   = '0;
                    d.phase = LN_IDLE;
                    d.valid = rxs;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RX_RESET;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign data_o  = q.shift;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW:0]                 wr;
        logic [AW:0]                 rd;
    } fifo_state_t;

    fifo_state_t q, d;
    logic        empty, full;

    assign empty = (q.wr == q.rd);
    assign full  = (q.wr[AW] != q.rd[AW]) && (q.wr[AW-1:0] == q.rd[AW-1:0]);

    always_comb begin
        d = q;
        if (push_i && !full) begin
            d.mem[q.wr[AW-1:0]] = data_i;
            d.wr                = q.wr + 1'b1;
        end
        if (pop_i && !empty) begin
            d.rd = q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mem <= '0;
            q.wr  <= '0;
            q.rd  <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_o  = q.mem[q.rd[AW-1:0]];
    assign empty_o = empty;
    assign full_o  = full;

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int          CLK_HZ     = 50_000_000,
    parameter int          BAUD       = 115_200,
    parameter int          FIFO_DEPTH = 16,
    parameter logic [31:0] BASE_ADDR  = 32'h1000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        uart_rx,
    output logic        uart_tx
);

    localparam int CPB       = (CLK_HZ + BAUD / 2) / BAUD;
    localparam int DATA_BITS = 8;
    localparam logic [31-WIN_BITS:0] BASE_HI = BASE_ADDR[31:WIN_BITS];

    typedef struct packed {
        logic [31:0] rdata;
    } bus_state_t;

    bus_state_t q, d;

    logic                 addr_hit;
    logic [WIN_BITS-1:0]  ofs;
    logic                 sel_tx_wr, sel_rx_rd, sel_st_rd;
    logic                 tx_busy, tx_start;
    logic                 fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [DATA_BITS-1:0] rx_byte, fifo_head;

    // Register decode
    assign addr_hit  = (bus_addr[31:WIN_BITS] == BASE_HI);
    assign ofs       = bus_addr[WIN_BITS-1:0];
    assign sel_tx_wr = addr_hit && bus_we && (ofs == OFS_TXD);
    assign sel_rx_rd = addr_hit && bus_re && (ofs == OFS_RXD);
    assign sel_st_rd = addr_hit && bus_re && (ofs == OFS_STAT);
    assign tx_start  = sel_tx_wr && !tx_busy;
    assign fifo_pop  = sel_rx_rd;

    uart_tx_engine #(
        .CPB       (CPB),
        .DATA_BITS (DATA_BITS)
    ) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tx_start),
        .data_i  (bus_wdata[DATA_BITS-1:0]),
        .busy_o  (tx_busy),
        .line_o  (uart_tx)
    );

    uart_rx_engine #(
        .CPB       (CPB),
        .DATA_BITS (DATA_BITS)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (uart_rx),
        .valid_o (fifo_push),
        .data_o  (rx_byte)
    );

    uart_rx_fifo #(
        .WIDTH (DATA_BITS),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .data_i  (rx_byte),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    // Read data path
    always_comb begin
        d.rdata = '0;
        if (sel_rx_rd && !fifo_empty) begin
            d.rdata[DATA_BITS-1:0] = fifo_head;
        end
        if (sel_st_rd) begin
            d.rdata[STAT_TX_BUSY]  = tx_busy;
            d.rdata[STAT_RX_AVAIL] = !fifo_empty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;

endmodule

// File: rtl/mmio_uart_checker.sv
module mmio_uart_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_re,
    input logic [31:0] bus_rdata,
    input logic        uart_tx,
    input logic        tx_busy,
    input logic        sel_tx_wr,
    input logic        sel_rx_rd,
    input logic        sel_st_rd,
    input logic        fifo_empty,
    input logic        fifo_full,
    input logic        fifo_pop
);

    p_undecoded_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !sel_rx_rd && !sel_st_rd) |=> (bus_rdata == 32'h0));

    p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !uart_tx);

    p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(sel_tx_wr));

    p_stop_high_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> uart_tx);

    p_status_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_st_rd |=> (bus_rdata[31:2] == 30'h0));

    p_busy_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && sel_tx_wr) |=> $stable(uart_tx) || tx_busy);

    p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rx_rd && fifo_empty) |=> (bus_rdata == 32'h0));

    p_status_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_st_rd |=> (bus_rdata[1] == !$past(fifo_empty)));

    p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop) |=> fifo_full);

    p_idle_line_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> uart_tx);

endmodule

bind mmio_uart mmio_uart_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .uart_tx    (uart_tx),
    .tx_busy    (tx_busy),
    .sel_tx_wr  (sel_tx_wr),
    .sel_rx_rd  (sel_rx_rd),
    .sel_st_rd  (sel_st_rd),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_pop   (fifo_pop)
);

// File: tb/test_mmio_uart.sv
`timescale 1ns/1ps
module test_mmio_uart;

    localparam int          T_CLK_HZ = 1_600_000;
    localparam int          T_BAUD   = 100_000;
    localparam int          BIT_CLKS = 16;         // 1_600_000 / 100_000
    localparam int          DEPTH    = 4;
    localparam logic [31:0] BASE     = 32'h1000_0000;
    localparam int          WATCHDOG = 190_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        uart_rx = 1'b1;
    logic        uart_tx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mmio_uart #(
        .CLK_HZ     (T_CLK_HZ),
        .BAUD       (T_BAUD),
        .FIFO_DEPTH (DEPTH),
        .BASE_ADDR  (BASE)
    ) i_mmio_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .uart_rx   (uart_rx),
        .uart_tx   (uart_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] wd);
        bus_addr  = a;
        bus_wdata = wd;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] rd);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        rd       = bus_rdata;
    endtask

    // Send one byte through the transmitter and sample every bit at its centre
    task automatic tx_frame(input logic [7:0] b, input bit interfere);
        logic [31:0] st;
        bus_write(BASE + 32'h0, {24'hA5C3F0, b});
        bus_read(BASE + 32'h8, st);
        check("R3 busy set after write", st, 32'h1);
        repeat (BIT_CLKS / 2 - 1) @(negedge clk);
        check("R2 start bit", {31'h0, uart_tx}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            if (interfere && i == 3) begin
                bus_write(BASE + 32'h0, 32'h0000_00C3);
                repeat (BIT_CLKS - 1) @(negedge clk);
            end else begin
                repeat (BIT_CLKS) @(negedge clk);
            end
            check(interfere ? "R4 data bit under busy write" : "R2 data bit",
                  {31'h0, uart_tx}, {31'h0, b[i]});
        end
        repeat (BIT_CLKS) @(negedge clk);
        check("R2 stop bit", {31'h0, uart_tx}, 32'h1);
        bus_read(BASE + 32'h8, st);
        check("R3 busy through stop bit", st, 32'h1);
        repeat (BIT_CLKS / 2) @(negedge clk);
        bus_read(BASE + 32'h8, st);
        check("R3 busy clear after stop", st, 32'h0);
    endtask

    // Drive one frame on the receive line
    task automatic rx_frame(input logic [7:0] b, input bit stop_ok);
        uart_rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        uart_rx = stop_ok;
        repeat (BIT_CLKS) @(negedge clk);
        uart_rx = 1'b1;
        repeat (stop_ok ? 2 : 2 * BIT_CLKS) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit          line_ok;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 line high after reset", {31'h0, uart_tx}, 32'h1);
        bus_read(BASE + 32'h8, rd);
        check("R11 status zero after reset", rd, 32'h0);
        bus_read(BASE + 32'h4, rd);
        check("R5 empty read returns zero", rd, 32'h0);

        // R2/R3 sweep over every byte value
        for (int b = 0; b < 256; b++) tx_frame(8'(b), 1'b0);

        // R4 write while busy is ignored
        tx_frame(8'h5A, 1'b1);
        line_ok = 1'b1;
        for (int k = 0; k < 3 * BIT_CLKS; k++) begin
            if (uart_tx !== 1'b1) line_ok = 1'b0;
            @(negedge clk);
        end
        check("R4 no frame after ignored write", {31'h0, line_ok}, 32'h1);

        // R5/R6 receive sweep over every byte value
        for (int b = 0; b < 256; b++) begin
            rx_frame(8'(b), 1'b1);
            bus_read(BASE + 32'h8, rd);
            check("R6 data available", rd, 32'h2);
            bus_read(BASE + 32'h8, rd);
            check("R6 status read has no side effect", rd, 32'h2);
            bus_read(BASE + 32'h4, rd);
            check("R5 received byte", rd, 32'(b));
            bus_read(BASE + 32'h8, rd);
            check("R5 read removed byte", rd, 32'h0);
        end

        // R7 start glitch
        uart_rx = 1'b0;
        repeat (3) @(negedge clk);
        uart_rx = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        bus_read(BASE + 32'h8, rd);
        check("R7 glitch rejected", rd, 32'h0);

        // R8 bad stop bit, then recovery
        rx_frame(8'h77, 1'b0);
        bus_read(BASE + 32'h8, rd);
        check("R8 framing error discarded", rd, 32'h0);
        rx_frame(8'h42, 1'b1);
        bus_read(BASE + 32'h4, rd);
        check("R8 next frame accepted", rd, 32'h42);

        // R9 overflow: one byte more than the queue holds
        for (int k = 0; k <= DEPTH; k++) rx_frame(8'(8'h10 + k), 1'b1);
        bus_read(BASE + 32'h8, rd);
        check("R9 queue holds data", rd, 32'h2);
        for (int k = 0; k < DEPTH; k++) begin
            bus_read(BASE + 32'h4, rd);
            check("R9 oldest bytes kept in order", rd, 32'(8'h10 + k));
        end
        bus_read(BASE + 32'h8, rd);
        check("R9 extra byte dropped", rd, 32'h0);
        bus_read(BASE + 32'h4, rd);
        check("R5 empty read after drain", rd, 32'h0);
        bus_read(BASE + 32'h8, rd);
        check("R5 empty read leaves queue empty", rd, 32'h0);

        // R10 writes to read-only offsets
        rx_frame(8'h99, 1'b1);
        bus_write(BASE + 32'h4, 32'h0000_0055);
        bus_write(BASE + 32'h8, 32'hFFFF_FFFF);
        bus_read(BASE + 32'h8, rd);
        check("R10 read-only writes leave status", rd, 32'h2);
        check("R10 line still idle", {31'h0, uart_tx}, 32'h1);
        bus_read(BASE + 32'h4, rd);
        check("R10 queued byte intact", rd, 32'h99);

        // R1 decode window
        rx_frame(8'h3C, 1'b1);
        bus_read(BASE + 32'h0, rd);
        check("R1 transmit offset reads zero", rd, 32'h0);
        bus_read(BASE + 32'hC, rd);
        check("R1 offset 0xC reads zero", rd, 32'h0);
        bus_read(BASE + 32'hFFC, rd);
        check("R1 offset 0xFFC reads zero", rd, 32'h0);
        bus_read(32'h1000_1004, rd);
        check("R1 next window not decoded", rd, 32'h0);
        bus_read(32'h2000_0004, rd);
        check("R1 foreign address reads zero", rd, 32'h0);
        bus_write(32'h2000_0000, 32'h0000_00AA);
        bus_read(BASE + 32'h8, rd);
        check("R1 foreign write starts nothing", rd, 32'h2);
        bus_read(BASE + 32'h4, rd);
        check("R1 foreign reads did not pop", rd, 32'h3C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule